// File: doc/BRIEF.md
# Reset and Wake Clock Sequencer

This block turns one free-running oscillator into the control signals that start and restart a small processor core. It divides the oscillator by four to make a core clock enable. It merges three reset causes into one system reset: a power-on pulse, a low-supply flag and a built-in watchdog. It then holds the core's run enable low until the oscillator has had time to settle. The settle time after a reset is long. The settle time after leaving the HALT low-power mode is short.

All logic runs on the oscillator clock. Every state change in the core-clock domain happens only on an oscillator edge where the core-clock enable is high (a "tick"). The power-on pulse, the low-supply flag and the watchdog overflow assert reset at once, without waiting for a clock edge. Reset is released through a two-stage synchronizer stepped by ticks. The remaining control inputs (watchdog enable, watchdog clear, halt request, wake event) are plain levels sampled at ticks. Every interface is control or status, so there is no valid/ready stream and no back-pressure.

Top module: `rst_clk_seq`

## Requirements
- R1: `sys_rst` goes high without waiting for a clock edge whenever `por_pulse` is high, or `lowv_flag` is high while `halt_mode` is 0, or the watchdog overflows.
- R2: After the last reset cause goes away, `sys_rst` stays high through the next tick and goes low on the second tick.
- R3: `mck_en` is high for exactly one oscillator cycle in every `CLK_DIV` cycles.
- R4: With `wdog_en` high, `halt_mode` 0 and no clear, the watchdog forces `sys_rst` high on the 2^`WDOG_BITS`-th tick after the last clear, and not before it.
- R5: A clear strobe sampled at a tick brings the watchdog count back to zero. The count also stays at zero while `wdog_en` is low or `halt_mode` is 1, so in any of these cases no watchdog reset occurs.
- R6: `run_en` rises on the `RESET_SETTLE`-th tick after `sys_rst` falls, and is low before that.
- R7: A `halt_req` sampled high at a tick while `run_en` is 1 makes `halt_mode` 1 and `run_en` 0 after that tick.
- R8: A `wake_evt` sampled at a tick while halted starts the wake settle. `run_en` rises, and `halt_mode` returns to 0, on the `WAKE_SETTLE`-th tick after the wake tick.
- R9: A `wake_evt` sampled during the wake settle restarts the wake count from zero.
- R10: `lowv_flag` has no effect while `halt_mode` is 1. `halt_mode` is 1 in HALT and during the wake settle.
- R11: Any system reset returns the block to the normal mode: `halt_mode` 0 and `run_en` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock; all logic runs on it |
| por_pulse | input | 1 | Power-on reset pulse, active high, asynchronous |
| lowv_flag | input | 1 | Low-supply comparator flag, active high |
| wdog_en | input | 1 | Watchdog enable level |
| wdog_clr | input | 1 | Watchdog clear strobe, sampled at ticks |
| halt_req | input | 1 | Request to enter HALT, sampled at ticks while running |
| wake_evt | input | 1 | Wake event, sampled at ticks while halted |
| mck_en | output | 1 | Core clock enable, oscillator divided by `CLK_DIV` |
| sys_rst | output | 1 | Combined system reset, active high |
| run_en | output | 1 | Core instruction execution permitted |
| halt_mode | output | 1 | 1 in HALT or wake settle, 0 in normal mode |

## Verification
The bench builds the block with an 8-bit watchdog, a reset settle of 20 ticks and a wake settle of 6 ticks. The divider stays at its default of four. These values bring watchdog overflow, settle completion and wake restart within a few thousand oscillator cycles. Each boundary can then be probed exactly one tick before and on the tick where it takes effect. The default values only lengthen the same counters.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic [1:0] {
    ST_SETTLE_RST  = 2'd0,
    ST_RUN         = 2'd1,
    ST_HALT        = 2'd2,
    ST_SETTLE_WAKE = 2'd3
  } rcs_state_e;
endpackage

// File: rtl/rcs_clkdiv.sv
module rcs_clkdiv #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic por_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)              cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (por_i)
    tick_o |=> !tick_o); // R3
endmodule

// File: rtl/rcs_rstsync.sv
module rcs_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic tick_i,
  input  logic raw_i,
  output logic rst_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or posedge raw_i) begin
    if (raw_i)       sh_q <= '1;
    else if (tick_i) sh_q <= {sh_q[STAGES-2:0], 1'b0};
  end

  assign rst_o = sh_q[STAGES-1];

  AST_RELEASE_ON_TICK: assert property (@(posedge clk_i)
    $fell(rst_o) |-> $past(tick_i)); // R2
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk_i) disable iff (raw_i)
    (rst_o && !tick_i) |=> rst_o); // R2
endmodule

// File: rtl/rcs_wdog.sv
module rcs_wdog #(
  parameter int BITS = 20
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_i,
  input  logic en_i,
  input  logic clr_i,
  input  logic hold_i,
  output logic ovf_o
);
  logic [BITS-1:0] cnt_q;
  logic            ovf_q;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (!en_i || hold_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (clr_i) begin
        cnt_q <= '0;
      end else begin
        if (&cnt_q) ovf_q <= 1'b1;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ovf_o = ovf_q;

  AST_WDOG_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (!en_i || hold_i) |=> (cnt_q == '0)); // R5
  AST_WDOG_STEP_ON_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
    (!tick_i && en_i && !hold_i) |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/rcs_settle.sv
module rcs_settle
  import rcs_pkg::*;
#(
  parameter int RST_CYC  = 2318,
  parameter int WAKE_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_i,
  input  logic halt_req_i,
  input  logic wake_i,
  output logic run_o,
  output logic halted_o
);
  localparam int MAXC = (RST_CYC > WAKE_CYC) ? RST_CYC : WAKE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] RST_LAST  = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYC - 1);

  rcs_state_e    state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      state_q <= ST_SETTLE_RST;
      cnt_q   <= '0;
    end else if (tick_i) begin
      case (state_q)
        ST_SETTLE_RST: begin
          if (cnt_q == RST_LAST) state_q <= ST_RUN;
          else                   cnt_q   <= cnt_q + 1'b1;
        end
        ST_RUN: begin
          if (halt_req_i) state_q <= ST_HALT;
        end
        ST_HALT: begin
          if (wake_i) begin
            state_q <= ST_SETTLE_WAKE;
            cnt_q   <= '0;
          end
        end
        default: begin
          if (wake_i)                  cnt_q   <= '0;
          else if (cnt_q == WAKE_LAST) state_q <= ST_RUN;
          else                         cnt_q   <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  assign run_o    = (state_q == ST_RUN);
  assign halted_o = (state_q == ST_HALT) || (state_q == ST_SETTLE_WAKE);

  AST_RUN_AFTER_FULL_COUNT: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_o && !$past(run_o)) |->
      ($past(cnt_q) == (($past(state_q) == ST_SETTLE_WAKE) ? WAKE_LAST : RST_LAST))); // R6
  AST_HALT_ENTRY: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_o && tick_i && halt_req_i) |=> (halted_o && !run_o)); // R7
  AST_WAKE_RESTART: assert property (@(posedge clk_i) disable iff (rst_i)
    ((state_q == ST_SETTLE_WAKE) && tick_i && wake_i) |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/rst_clk_seq.sv
module rst_clk_seq #(
  parameter int CLK_DIV      = 4,
  parameter int WDOG_BITS    = 20,
  parameter int RESET_SETTLE = 2318,
  parameter int WAKE_SETTLE  = 64
) (
  input  logic osc_clk,
  input  logic por_pulse,
  input  logic lowv_flag,
  input  logic wdog_en,
  input  logic wdog_clr,
  input  logic halt_req,
  input  logic wake_evt,
  output logic mck_en,
  output logic sys_rst,
  output logic run_en,
  output logic halt_mode
);
  logic tick;
  logic wdog_ovf;
  logic halted;
  logic raw_rst;

  rcs_clkdiv #(.DIV(CLK_DIV)) u_div (
    .clk_i  (osc_clk),
    .por_i  (por_pulse),
    .tick_o (tick)
  );

  assign raw_rst = por_pulse | (lowv_flag & ~halted) | wdog_ovf;

  rcs_rstsync #(.STAGES(2)) u_sync (
    .clk_i  (osc_clk),
    .tick_i (tick),
    .raw_i  (raw_rst),
    .rst_o  (sys_rst)
  );

  rcs_wdog #(.BITS(WDOG_BITS)) u_wdog (
    .clk_i  (osc_clk),
    .rst_i  (sys_rst),
    .tick_i (tick),
    .en_i   (wdog_en),
    .clr_i  (wdog_clr),
    .hold_i (halted),
    .ovf_o  (wdog_ovf)
  );

  rcs_settle #(.RST_CYC(RESET_SETTLE), .WAKE_CYC(WAKE_SETTLE)) u_settle (
    .clk_i      (osc_clk),
    .rst_i      (sys_rst),
    .tick_i     (tick),
    .halt_req_i (halt_req),
    .wake_i     (wake_evt),
    .run_o      (run_en),
    .halted_o   (halted)
  );

  assign mck_en    = tick;
  assign halt_mode = halted;

  AST_LOWV_RESETS: assert property (@(posedge osc_clk) disable iff (por_pulse)
    (lowv_flag && !halt_mode) |-> sys_rst); // R1
  AST_RESET_TO_NORMAL: assert property (@(posedge osc_clk) disable iff (por_pulse)
    $fell(sys_rst) |-> (!halt_mode && !run_en)); // R11
endmodule

// File: tb/rst_clk_seq_tb_top.sv
module rst_clk_seq_tb_top;
  localparam int DIV   = 4;
  localparam int WBITS = 8;
  localparam int RSET  = 20;
  localparam int WSET  = 6;

  logic osc_clk = 1'b0;
  logic por_pulse = 1'b0;
  logic lowv_flag = 1'b0;
  logic wdog_en = 1'b0;
  logic wdog_clr = 1'b0;
  logic halt_req = 1'b0;
  logic wake_evt = 1'b0;
  logic mck_en, sys_rst, run_en, halt_mode;

  int checks = 0;
  int errors = 0;

  always #5 osc_clk = ~osc_clk;

  rst_clk_seq #(
    .CLK_DIV(DIV), .WDOG_BITS(WBITS), .RESET_SETTLE(RSET), .WAKE_SETTLE(WSET)
  ) dut_i (
    .osc_clk(osc_clk), .por_pulse(por_pulse), .lowv_flag(lowv_flag),
    .wdog_en(wdog_en), .wdog_clr(wdog_clr), .halt_req(halt_req),
    .wake_evt(wake_evt), .mck_en(mck_en), .sys_rst(sys_rst),
    .run_en(run_en), .halt_mode(halt_mode)
  );

  // fields: [15]halt [14]wake [13]lowv [12]exp_rst [11]exp_run [10]exp_halt [9:0]ticks
  localparam logic [15:0] VEC [0:12] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd1},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd5},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 10'd2},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 10'd1},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd4},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd1},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 10'd1},
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd1},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 10'd1},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 10'd2},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 10'd1},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd5},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 10'd1}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // advance n core ticks; returns at a falling edge after the last tick
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge osc_clk); while (!mck_en);
      @(negedge osc_clk);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge osc_clk);
    errors++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    finish_run();
  end

  initial begin
    int cnt;
    #1 por_pulse = 1'b1;
    repeat (10) @(negedge osc_clk);
    chk("R1 power-on reset", sys_rst, 1'b1);
    chk("R11 run off in reset", run_en, 1'b0);
    chk("R11 normal mode in reset", halt_mode, 1'b0);
    por_pulse = 1'b0;
    ticks(1);
    chk("R2 held one tick", sys_rst, 1'b1);
    ticks(1);
    chk("R2 released second tick", sys_rst, 1'b0);
    ticks(RSET - 1);
    chk("R6 not yet running", run_en, 1'b0);
    ticks(1);
    chk("R6 running after settle", run_en, 1'b1);

    cnt = 0;
    for (int i = 0; i < 10 * DIV; i++) begin
      @(negedge osc_clk);
      if (mck_en) cnt++;
    end
    chk("R3 enable rate", cnt == 10, 1'b1);

    for (int r = 0; r < 13; r++) begin
      halt_req  = VEC[r][15];
      wake_evt  = VEC[r][14];
      lowv_flag = VEC[r][13];
      ticks(int'(VEC[r][9:0]));
      chk($sformatf("R10 R7 R8 R9 row %0d sys_rst", r), sys_rst, VEC[r][12]);
      chk($sformatf("R7 R8 R9 row %0d run_en", r), run_en, VEC[r][11]);
      chk($sformatf("R7 R8 R10 row %0d halt_mode", r), halt_mode, VEC[r][10]);
      halt_req = 1'b0; wake_evt = 1'b0; lowv_flag = 1'b0;
    end

    wdog_en = 1'b1; wdog_clr = 1'b1;
    ticks(1);
    wdog_clr = 1'b0;
    ticks(200);
    wdog_clr = 1'b1;
    ticks(1);
    wdog_clr = 1'b0;
    ticks(200);
    chk("R5 cleared watchdog quiet", sys_rst, 1'b0);
    ticks(2 ** WBITS - 200 - 1);
    chk("R4 one tick before overflow", sys_rst, 1'b0);
    ticks(1);
    chk("R4 overflow reset", sys_rst, 1'b1);
    wdog_en = 1'b0;
    ticks(2);
    chk("R2 release after watchdog", sys_rst, 1'b0);
    ticks(RSET);
    chk("R6 running after watchdog", run_en, 1'b1);
    ticks(300);
    chk("R5 disabled watchdog quiet", sys_rst, 1'b0);

    halt_req = 1'b1;
    ticks(1);
    halt_req = 1'b0;
    wdog_en = 1'b1;
    ticks(300);
    chk("R5 halted watchdog quiet", sys_rst, 1'b0);
    chk("R5 still halted", halt_mode, 1'b1);
    wdog_en = 1'b0;

    por_pulse = 1'b1;
    @(negedge osc_clk);
    chk("R11 reset leaves halt", halt_mode, 1'b0);
    chk("R1 por in halt", sys_rst, 1'b1);
    por_pulse = 1'b0;
    ticks(2 + RSET);
    chk("R6 running after por", run_en, 1'b1);

    lowv_flag = 1'b1;
    @(negedge osc_clk);
    chk("R1 low supply reset", sys_rst, 1'b1);
    chk("R11 low supply stops run", run_en, 1'b0);
    lowv_flag = 1'b0;
    ticks(1);
    chk("R2 low supply held", sys_rst, 1'b1);
    ticks(1);
    chk("R2 low supply released", sys_rst, 1'b0);

    finish_run();
  end
endmodule